// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, a weekday index, day of month, month and a sixteen-bit year whose upper byte holds the century. It advances on a 128 Hz tick pulse supplied by the surrounding logic. A 7-bit sub-second counter divides the tick down to one-second steps. The step then ripples through the fields in a single clock edge, with month lengths and the leap-year rule applied to the four-digit year.

Software reaches every field through a small register bus with separate write and read strobes. A second control register gates counting and can hold the sub-second stage at zero, so that a consistent time can be loaded while the count is frozen. A sticky carry flag records every one-second step. Software clears the flag, reads the fields, then checks the flag again; if it is set, a step landed inside the read sequence and the read is repeated. An enable routes the flag to an interrupt output.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous reset, the fields read as follows: sub-second 0, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01, year 0x2000, and both control registers 0.
- R2: A read strobe at one clock edge returns data on `rdata` with `rd_valid` high after that edge. Register addresses are: 0 sub-second (binary, read-only), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year (all 16 bits), 14 control 1, 15 control 2. Eight-bit registers use `rdata[7:0]` and read zero above that.
- R3: Seconds and minutes each count 0x00 to 0x59 in BCD. On a step at 0x59 the field returns to 0x00 and the next field up advances.
- R4: Hours count 0x00 to 0x23. Wrapping from 0x23 advances the day of month and the weekday. The weekday counts 0 to 6 and then returns to 0.
- R5: The day of month returns to 0x01 after day 0x30 in months 04, 06, 09 and 11, and after day 0x31 in the other non-February months. The month field then advances, and month 0x12 wraps to 0x01 and advances the year.
- R6: February ends after 0x29 in a leap year and after 0x28 otherwise. A year is a leap year when its low byte is a multiple of 4. When the low byte is 0x00, the century byte must be a multiple of 4 instead.
- R7: The year low byte counts 0x00 to 0x99. Wrapping from 0x99 advances the century byte, which itself wraps from 0x99 to 0x00.
- R8: While counting is enabled, each `tick` advances the sub-second counter by one. Its wrap from 127 to 0 produces exactly one seconds step.
- R9: Control 1 bit 7 is the carry flag and bit 4 is the carry interrupt enable. The flag sets on every seconds step. Writing control 1 with bit 7 = 0 clears the flag and bit 7 = 1 leaves it unchanged. A seconds step in the same cycle as a clearing write leaves the flag set. `carry_irq` is high exactly while both the flag and its enable are 1.
- R10: Control 2 bit 0 is start and bit 3 is enable. Ticks are counted only while both bits are 1; otherwise every field holds its value.
- R11: While control 2 bit 1 (prescaler reset) is 1, the sub-second counter stays at 0 and no seconds step occurs.
- R12: Writes to addresses 1 to 7 take effect only while start is 0. While start is 1 they are ignored, and no write changes any other field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 128 Hz count pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | `rdata` holds the result of the previous read strobe |
| carry_irq | output | 1 | Carry flag AND carry interrupt enable |

## Verification
The carry flag has two sources that can act in the same edge: the hardware sets it on a seconds step, and software clears it by writing control 1. The bench advances the sub-second counter to 127. It then drives the last tick together with a control-1 write that has bit 7 at 0. The expected result is the flag still set, `carry_irq` high and the seconds field one higher. Every rollover path is checked the same way: the fields are loaded one second before the boundary under test, exactly 128 ticks are applied, and each field is read back through the bus.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned YEAR_W = 16;

  localparam logic [ADDR_W-1:0] A_SUB  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd3;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd4;
  localparam logic [ADDR_W-1:0] A_DAY  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTL1 = 4'd14;
  localparam logic [ADDR_W-1:0] A_CTL2 = 4'd15;

  localparam logic [YEAR_W-1:0] YEAR_RST = 16'h2000;

  // packed BCD increment of a two-digit byte
  function automatic logic [BYTE_W-1:0] bcd_inc8(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // two-digit BCD value divisible by four: (10t+u) mod 4 == (2t+u) mod 4
  function automatic logic bcd_div4(input logic [BYTE_W-1:0] v);
    logic [3:0] s;
    s = v[3:0] + {2'b00, v[4], 1'b0};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic is_leap(input logic [YEAR_W-1:0] y);
    if (y[7:0] == 8'h00) return bcd_div4(y[15:8]);
    return bcd_div4(y[7:0]);
  endfunction

  function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] mon,
                                                 input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_subsec_prescaler.sv
module rtc_subsec_prescaler #(
  parameter int unsigned SUB_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             hold,
  output logic [SUB_W-1:0] count,
  output logic             sec_step
);
  localparam logic [SUB_W-1:0] LAST = {SUB_W{1'b1}};

  assign sec_step = tick && run && !hold && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || hold) count <= '0;
    else if (tick && run) count <= count + 1'b1;
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MIN_V = 8'h00,
  parameter logic [7:0] MAX_V = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] value,
  output logic       wrap
);
  import rtc_cal_pkg::*;

  assign wrap = step && (value >= MAX_V);

  always_ff @(posedge clk) begin
    if (rst)       value <= MIN_V;
    else if (load) value <= load_val;
    else if (step) value <= wrap ? MIN_V : bcd_inc8(value);
  end
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        day_step,
  input  logic        load_day,
  input  logic        load_mon,
  input  logic        load_year,
  input  logic [15:0] wdata,
  output logic [7:0]  day,
  output logic [7:0]  mon,
  output logic [15:0] year
);
  import rtc_cal_pkg::*;

  logic [7:0] dmax;
  logic       day_wrap;
  logic       year_step;

  assign dmax     = last_day(mon, is_leap(year));
  assign day_wrap = day_step && (day >= dmax);

  always_ff @(posedge clk) begin
    if (rst)           day <= 8'h01;
    else if (load_day) day <= wdata[7:0];
    else if (day_step) day <= day_wrap ? 8'h01 : bcd_inc8(day);
  end

  rtc_bcd_field #(.MIN_V(8'h01), .MAX_V(8'h12)) u_mon (
    .clk(clk), .rst(rst), .step(day_wrap), .load(load_mon),
    .load_val(wdata[7:0]), .value(mon), .wrap(year_step)
  );

  always_ff @(posedge clk) begin
    if (rst)            year <= YEAR_RST;
    else if (load_year) year <= wdata;
    else if (year_step) begin
      if (year[7:0] >= 8'h99)
        year <= {(year[15:8] >= 8'h99) ? 8'h00 : bcd_inc8(year[15:8]), 8'h00};
      else
        year[7:0] <= bcd_inc8(year[7:0]);
    end
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int unsigned SUB_W = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rd_valid,
  output logic        carry_irq
);
  import rtc_cal_pkg::*;

  localparam int unsigned N_TOD = 3;

  logic             start_q, en_q, prst_q, flag_q, cie_q;
  logic             run, sec_step, field_wr;
  logic [SUB_W-1:0] subsec;
  logic [7:0]       tod_val [N_TOD];
  logic [N_TOD-1:0] tod_wrap;
  logic [7:0]       wday, day, mon;
  logic [15:0]      year;
  logic [7:0]       sec_val;
  logic             wday_wrap_unused;
  logic [15:0]      rd_next;

  assign run      = start_q && en_q;
  assign field_wr = wr_en && !start_q;
  assign sec_val  = tod_val[0];

  rtc_subsec_prescaler #(.SUB_W(SUB_W)) u_presc (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .hold(prst_q),
    .count(subsec), .sec_step(sec_step)
  );

  // seconds, minutes, hours chained
  for (genvar i = 0; i < N_TOD; i++) begin : g_tod
    localparam logic [7:0] TOP  = (i == N_TOD - 1) ? 8'h23 : 8'h59;
    localparam logic [3:0] MY_A = A_SEC + 4'(i);
    logic step_i;
    if (i == 0) begin : g_first
      assign step_i = sec_step;
    end else begin : g_next
      assign step_i = tod_wrap[i-1];
    end
    rtc_bcd_field #(.MIN_V(8'h00), .MAX_V(TOP)) u_fld (
      .clk(clk), .rst(rst), .step(step_i),
      .load(field_wr && (addr == MY_A)), .load_val(wdata[7:0]),
      .value(tod_val[i]), .wrap(tod_wrap[i])
    );
  end

  rtc_bcd_field #(.MIN_V(8'h00), .MAX_V(8'h06)) u_wday (
    .clk(clk), .rst(rst), .step(tod_wrap[N_TOD-1]),
    .load(field_wr && (addr == A_WDAY)), .load_val(wdata[7:0]),
    .value(wday), .wrap(wday_wrap_unused)
  );

  rtc_date_unit u_date (
    .clk(clk), .rst(rst), .day_step(tod_wrap[N_TOD-1]),
    .load_day(field_wr && (addr == A_DAY)),
    .load_mon(field_wr && (addr == A_MON)),
    .load_year(field_wr && (addr == A_YEAR)),
    .wdata(wdata), .day(day), .mon(mon), .year(year)
  );

  // control registers; a seconds step wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      en_q    <= 1'b0;
      prst_q  <= 1'b0;
      flag_q  <= 1'b0;
      cie_q   <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTL2) begin
        start_q <= wdata[0];
        prst_q  <= wdata[1];
        en_q    <= wdata[3];
      end
      if (wr_en && addr == A_CTL1) cie_q <= wdata[4];
      if (sec_step) flag_q <= 1'b1;
      else if (wr_en && addr == A_CTL1) flag_q <= flag_q & wdata[7];
    end
  end

  assign carry_irq = flag_q && cie_q;

  always_comb begin
    rd_next = '0;
    case (addr)
      A_SUB:  rd_next[SUB_W-1:0] = subsec;
      A_SEC:  rd_next[7:0] = tod_val[0];
      A_MIN:  rd_next[7:0] = tod_val[1];
      A_HOUR: rd_next[7:0] = tod_val[2];
      A_WDAY: rd_next[7:0] = wday;
      A_DAY:  rd_next[7:0] = day;
      A_MON:  rd_next[7:0] = mon;
      A_YEAR: rd_next      = year;
      A_CTL1: begin
        rd_next[7] = flag_q;
        rd_next[4] = cie_q;
      end
      A_CTL2: begin
        rd_next[3] = en_q;
        rd_next[1] = prst_q;
        rd_next[0] = start_q;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker #(
  parameter int unsigned SUB_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sec_step,
  input logic             run,
  input logic             hold,
  input logic [SUB_W-1:0] subsec,
  input logic [7:0]       sec,
  input logic             flag,
  input logic             wr_en,
  input logic             start,
  input logic [3:0]       addr,
  input logic             rd_en,
  input logic             rd_valid
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_step && sec == 8'h59) |=> (sec == 8'h00));

  assert_flag_sets_R9: assert property (@(posedge clk) disable iff (rst)
    sec_step |=> flag);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!run && !hold) |=> $stable(subsec));

  assert_hold_zero_R11: assert property (@(posedge clk) disable iff (rst)
    hold |=> (subsec == '0));

  assert_locked_write_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && start && addr == 4'd1 && !sec_step) |=> $stable(sec));
endmodule

bind rtc_calendar_core rtc_calendar_checker #(.SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst(rst), .sec_step(sec_step), .run(run), .hold(prst_q),
  .subsec(subsec), .sec(sec_val), .flag(flag_q), .wr_en(wr_en),
  .start(start_q), .addr(addr), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic        carry_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rtc_calendar_core dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .carry_irq(carry_irq)
  );

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read result: actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_pin(input logic act, input logic e, input string t);
    n_checks++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                           input logic [15:0] y);
    bus_wr(4'd15, 16'h000A);
    bus_wr(4'd1, {8'h00, s});
    bus_wr(4'd2, {8'h00, m});
    bus_wr(4'd3, {8'h00, h});
    bus_wr(4'd4, {8'h00, w});
    bus_wr(4'd5, {8'h00, d});
    bus_wr(4'd6, {8'h00, mo});
    bus_wr(4'd7, y);
    bus_wr(4'd15, 16'h0009);
  endtask

  // one second from 23:59:59 on the given date
  task automatic roll_day(input logic [7:0] d, input logic [7:0] mo, input logic [15:0] y,
                          input logic [7:0] ed, input logic [7:0] emo, input logic [15:0] ey,
                          input string t);
    load_time(8'h59, 8'h59, 8'h23, 8'h03, d, mo, y);
    ticks(128);
    expect_rd(4'd3, 16'h0000, {t, " hour"});
    expect_rd(4'd5, {8'h00, ed}, {t, " day"});
    expect_rd(4'd6, {8'h00, emo}, {t, " month"});
    expect_rd(4'd7, ey, {t, " year"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and R2 map
    expect_rd(4'd0, 16'h0000, "R1 sub-second");
    expect_rd(4'd1, 16'h0000, "R1 seconds");
    expect_rd(4'd2, 16'h0000, "R1 minutes");
    expect_rd(4'd3, 16'h0000, "R1 hours");
    expect_rd(4'd4, 16'h0000, "R1 weekday");
    expect_rd(4'd5, 16'h0001, "R1 day");
    expect_rd(4'd6, 16'h0001, "R1 month");
    expect_rd(4'd7, 16'h2000, "R2 R1 year");
    expect_rd(4'd14, 16'h0000, "R1 control1");
    expect_rd(4'd15, 16'h0000, "R1 control2");
    check_pin(carry_irq, 1'b0, "R1 carry_irq");

    // R10 stopped: ticks ignored
    ticks(5);
    expect_rd(4'd0, 16'h0000, "R10 sub-second frozen");
    // R8 running
    bus_wr(4'd15, 16'h0009);
    ticks(5);
    expect_rd(4'd0, 16'h0005, "R8 sub-second count");
    expect_rd(4'd15, 16'h0009, "R2 control2 readback");
    // R10 enable bit cleared with start set
    bus_wr(4'd15, 16'h0001);
    ticks(7);
    expect_rd(4'd0, 16'h0005, "R10 enable low holds");

    // R11 prescaler reset holds zero
    bus_wr(4'd15, 16'h000B);
    ticks(200);
    expect_rd(4'd0, 16'h0000, "R11 sub-second held");
    expect_rd(4'd1, 16'h0000, "R11 no seconds step");

    // R3 minute carry, R8 one step per 128 ticks
    load_time(8'h59, 8'h00, 8'h00, 8'h02, 8'h15, 8'h06, 16'h2030);
    ticks(127);
    expect_rd(4'd1, 16'h0059, "R8 no step before wrap");
    ticks(1);
    expect_rd(4'd1, 16'h0000, "R3 seconds wrap");
    expect_rd(4'd2, 16'h0001, "R3 minute carry");
    expect_rd(4'd3, 16'h0000, "R3 hour unchanged");
    expect_rd(4'd0, 16'h0000, "R8 sub-second wrapped");

    // R9 carry flag
    expect_rd(4'd14, 16'h0080, "R9 flag set");
    check_pin(carry_irq, 1'b0, "R9 irq masked");
    bus_wr(4'd14, 16'h0090);
    check_pin(carry_irq, 1'b1, "R9 irq enabled");
    expect_rd(4'd14, 16'h0090, "R9 write one keeps flag");
    bus_wr(4'd14, 16'h0010);
    check_pin(carry_irq, 1'b0, "R9 irq after clear");
    expect_rd(4'd14, 16'h0010, "R9 flag cleared");

    // R12 writes ignored while running
    bus_wr(4'd1, 16'h0030);
    bus_wr(4'd5, 16'h0009);
    expect_rd(4'd1, 16'h0000, "R12 seconds kept");
    expect_rd(4'd5, 16'h0015, "R12 day kept");
    expect_rd(4'd2, 16'h0001, "R12 minutes untouched");

    // R9 set and clear in the same cycle
    ticks(127);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 4'd14; wdata = 16'h0010;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check_pin(carry_irq, 1'b1, "R9 set wins irq");
    expect_rd(4'd14, 16'h0090, "R9 set wins flag");
    expect_rd(4'd1, 16'h0001, "R9 seconds stepped");
    bus_wr(4'd14, 16'h0000);
    check_pin(carry_irq, 1'b0, "R9 irq off");

    // R4 hour and weekday wrap, R5 31-day month
    load_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h07, 16'h2030);
    ticks(128);
    expect_rd(4'd3, 16'h0000, "R4 hour wrap");
    expect_rd(4'd4, 16'h0000, "R4 weekday wrap");
    expect_rd(4'd5, 16'h0001, "R5 day after 31");
    expect_rd(4'd6, 16'h0008, "R5 month advance");
    // R4 weekday plain increment, day plain increment
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h09, 8'h10, 16'h2030);
    ticks(128);
    expect_rd(4'd4, 16'h0003, "R4 weekday step");
    expect_rd(4'd5, 16'h0010, "R4 day BCD carry");

    roll_day(8'h30, 8'h04, 16'h2030, 8'h01, 8'h05, 16'h2030, "R5 April end");
    roll_day(8'h30, 8'h05, 16'h2030, 8'h31, 8'h05, 16'h2030, "R5 May 30");
    roll_day(8'h31, 8'h12, 16'h2099, 8'h01, 8'h01, 16'h2100, "R7 century carry");
    roll_day(8'h31, 8'h12, 16'h2019, 8'h01, 8'h01, 16'h2020, "R7 year BCD carry");
    roll_day(8'h28, 8'h02, 16'h2023, 8'h01, 8'h03, 16'h2023, "R6 common Feb");
    roll_day(8'h28, 8'h02, 16'h2024, 8'h29, 8'h02, 16'h2024, "R6 leap Feb 28");
    roll_day(8'h29, 8'h02, 16'h2024, 8'h01, 8'h03, 16'h2024, "R6 leap Feb 29");
    roll_day(8'h28, 8'h02, 16'h2100, 8'h01, 8'h03, 16'h2100, "R6 century non-leap");
    roll_day(8'h28, 8'h02, 16'h2000, 8'h29, 8'h02, 16'h2000, "R6 century leap");
    roll_day(8'h31, 8'h12, 16'h9999, 8'h01, 8'h01, 16'h0000, "R7 century wrap");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 reads unanswered: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule